// File: doc/BRIEF.md
# Modular Programmable Divider Chain

This block divides an input event stream by a programmable integer. It is built from a row of identical divide-by-2/3 cells. Each cell counts the events handed to it by the cell before it. Once per period it may stretch one of its own cycles by a single input event. It does this when its ratio bit is set and the cell behind it is asking for an extra event. The cell at the end of the row always asks, because its modulus input is tied high. No cell holds a loadable count. Each cell swallows its share of the cycles, so the weights of the ratio bits follow from where each cell sits in the row.

Input events arrive as single-cycle enables in one clock domain. The block gives two outputs: a pulse once per output period, and a divided clock level taken from the last cell. With the default nine cells the ratio can be anything from 512 to 1023. This covers, for example, bringing a clock of roughly 30 GHz down to a 50 MHz comparison rate with ratios from 560 to 640. The ratio word is taken only at period boundaries, so no period ever mixes two ratios.

Top module: `modular_ratio_divider`

## Requirements
- R1: The number of `in_en_i` events from one `period_o` pulse to the next equals 2^N_CELLS + `ratio_i`. Bit k of the word carries weight 2^k, and bit 0 belongs to the cell that receives `in_en_i` directly.
- R2: A word of all zeros gives the shortest period, 2^N_CELLS events (512 for nine cells). A word of all ones gives the longest, 2^(N_CELLS+1)-1 events (1023 for nine cells).
- R3: `period_o` is high for exactly one clock, in the cycle after the rising edge that samples the event completing a period.
- R4: `div_clk_o` rises only in a cycle in which `period_o` is high. It goes low exactly once in each output period.
- R5: `ratio_i` is sampled only at the edge of the event that completes a period. A change at any other time leaves the running period unchanged and applies from the next period on.
- R6: While `rst_ni` is low and right after it rises, `period_o` is 0 and `div_clk_o` is 1.
- R7: A cycle with `in_en_i` low changes nothing. `div_clk_o` holds its value, no pulse is given, and only enabled cycles count towards a period.
- R8: The first period after reset is a full period, counted from the first event. It uses the word present at that first event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | One input event per high cycle |
| ratio_i | input | N_CELLS | Ratio word added to 2^N_CELLS; bit 0 weighs 1 |
| div_clk_o | output | 1 | Divided clock level from the last cell |
| period_o | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The bench first holds `in_en_i` high. It steps the word across the whole range and walks one word at a time through the band that corresponds to 560..640, so that every bit weight and the carries between cells give a distinct period length. The two endpoint words are checked apart from the rest, because they separate a chain that never stretches from one that stretches in every cell. The word is changed partway through a period to show that the running period keeps its old length and the next one takes the new length. A gapped enable pattern from a shift register confirms that idle cycles neither count nor move the outputs.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;
   typedef enum logic [1:0] {
      PH_REST = 2'd0,
      PH_MID  = 2'd1,
      PH_XTRA = 2'd2
   } cell_ph_e;

   localparam int unsigned MAX_CELLS = 24;
endpackage

// File: rtl/mrd_cell.sv
`timescale 1ns/1ps
module mrd_cell
   import mrd_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ev_i,
   input  logic swallow_i,
   input  logic mod_i,
   output logic ev_o,
   output logic mod_o
);
   cell_ph_e ph_q, ph_d;
   logic     stretch;
   logic     closing;

   // one extra input event when this bit is set and the cell behind requests it
   assign stretch = swallow_i & mod_i;
   assign closing = (ph_q == PH_XTRA) | ((ph_q == PH_MID) & ~stretch);
   assign ev_o    = ev_i & closing;
   assign mod_o   = mod_i & closing;

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_REST: ph_d = PH_MID;
         PH_MID:  ph_d = stretch ? PH_XTRA : PH_REST;
         PH_XTRA: ph_d = PH_REST;
         default: ph_d = PH_REST;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ph_q <= PH_REST;
      else if (ev_i) ph_q <= ph_d;
   end

   p_phase_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ph_q inside {PH_REST, PH_MID, PH_XTRA});

   p_stretch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i && ph_q == PH_MID && swallow_i && mod_i) |=> (ph_q == PH_XTRA));

   p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ev_i |=> $stable(ph_q));
endmodule

// File: rtl/mrd_ratio_hold.sv
`timescale 1ns/1ps
module mrd_ratio_hold #(
   parameter int unsigned WORD_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ev_i,
   input  logic              wrap_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   logic              start_q;
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q <= 1'b1;
         word_q  <= '0;
      end else if (ev_i) begin
         start_q <= 1'b0;
         if (start_q || wrap_i) word_q <= word_i;
      end
   end

   assign word_o = word_q;

   p_word_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_i || (!wrap_i && !start_q)) |=> $stable(word_o));
endmodule

// File: rtl/mrd_out.sv
`timescale 1ns/1ps
module mrd_out (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wrap_i,
   input  logic tail_ev_i,
   output logic period_o,
   output logic div_clk_o
);
   logic period_q;
   logic div_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         period_q <= 1'b0;
         div_q    <= 1'b1;
      end else begin
         period_q <= wrap_i;
         if (wrap_i)         div_q <= 1'b1;
         else if (tail_ev_i) div_q <= 1'b0;
      end
   end

   assign period_o  = period_q;
   assign div_clk_o = div_q;

   p_div_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_q) |-> period_q);

   p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_q |=> !period_q);
endmodule

// File: rtl/modular_ratio_divider.sv
`timescale 1ns/1ps
module modular_ratio_divider #(
   parameter int unsigned N_CELLS = 9
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               in_en_i,
   input  logic [N_CELLS-1:0] ratio_i,
   output logic               div_clk_o,
   output logic               period_o
);
   localparam int unsigned CNT_W = N_CELLS + 1;
   localparam logic [CNT_W-1:0] ONE_C = 1;

   if (N_CELLS < 2 || N_CELLS > mrd_pkg::MAX_CELLS) begin : g_bad_cells
      $error("modular_ratio_divider: N_CELLS out of supported range");
   end

   logic [N_CELLS:0]   ev;
   logic [N_CELLS:0]   mod;
   logic [N_CELLS-1:0] word;

   assign ev[0]        = in_en_i;
   assign mod[N_CELLS] = 1'b1;   // last cell always requests

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      mrd_cell u_cell (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .ev_i     (ev[i]),
         .swallow_i(word[i]),
         .mod_i    (mod[i+1]),
         .ev_o     (ev[i+1]),
         .mod_o    (mod[i])
      );
   end

   mrd_ratio_hold #(.WORD_W(N_CELLS)) u_hold (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ev_i  (in_en_i),
      .wrap_i(ev[N_CELLS]),
      .word_i(ratio_i),
      .word_o(word)
   );

   mrd_out u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wrap_i   (ev[N_CELLS]),
      .tail_ev_i(ev[N_CELLS-1]),
      .period_o (period_o),
      .div_clk_o(div_clk_o)
   );

   // event counter watched by the period-length property
   logic [CNT_W-1:0] seen_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      seen_q <= '0;
      else if (in_en_i) seen_q <= ev[N_CELLS] ? '0 : seen_q + ONE_C;
   end

   p_period_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_en_i && ev[N_CELLS]) |-> ((seen_q + ONE_C) == {1'b1, word}));

   p_head_mod_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[N_CELLS] |-> mod[0]);
endmodule

// File: tb/modular_ratio_divider_tb_top.sv
`timescale 1ns/1ps
module modular_ratio_divider_tb_top;
   localparam int N    = 9;
   localparam int BASE = 1 << N;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_en = 1'b0;
   logic [N-1:0] ratio = '0;
   logic         div_clk_o;
   logic         period_o;

   always #2 clk = ~clk;

   modular_ratio_divider #(.N_CELLS(N)) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .in_en_i  (in_en),
      .ratio_i  (ratio),
      .div_clk_o(div_clk_o),
      .period_o (period_o)
   );

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference model, updated at each rising edge
   int m_cnt = 0, m_ratio = 0, meas_cnt = 0;
   bit m_start = 1, m_exp = 0, en_last = 0;
   always @(posedge clk) begin
      en_last = in_en;
      if (!rst_n) begin
         m_start = 1; m_cnt = 0; m_exp = 0; m_ratio = 0; meas_cnt = 0;
      end else begin
         m_exp = 0;
         if (in_en) begin
            meas_cnt++;
            if (m_start) begin m_ratio = BASE + int'(ratio); m_start = 0; end
            m_cnt++;
            if (m_cnt == m_ratio) begin
               m_exp = 1; m_cnt = 0; m_ratio = BASE + int'(ratio);
            end
         end
      end
   end

   // comparison on every clock, away from the active edge
   int last_meas = 0, falls = 0, pulses = 0;
   bit prev_div = 1;
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk(period_o == m_exp, "R1 R3 pulse timing", period_o, m_exp);
         if (!en_last) begin
            chk(div_clk_o == prev_div, "R7 idle cycle holds div clock", div_clk_o, prev_div);
            chk(period_o == 1'b0, "R7 idle cycle gives no pulse", period_o, 0);
         end
         if (div_clk_o && !prev_div) chk(period_o, "R4 rise only with pulse", period_o, 1);
         if (!div_clk_o && prev_div) falls++;
         if (period_o) begin
            chk(div_clk_o == 1'b1, "R4 high at pulse", div_clk_o, 1);
            chk(falls == 1, "R4 one low phase per period", falls, 1);
            last_meas = meas_cnt; meas_cnt = 0; falls = 0; pulses++;
         end
      end
      prev_div = div_clk_o;
      if (cycles > 190000 && !done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   task automatic wait_pulse();
      do begin @(negedge clk); #1; end while (!period_o);
   endtask

   initial begin
      int prev;
      logic [15:0] lfsr;
      in_en = 0; ratio = N'(48);
      repeat (4) @(negedge clk);
      chk(period_o == 1'b0, "R6 pulse low in reset", period_o, 0);
      chk(div_clk_o == 1'b1, "R6 div clock high in reset", div_clk_o, 1);
      rst_n = 1;
      @(negedge clk);
      chk(period_o == 1'b0, "R6 pulse low after reset", period_o, 0);
      chk(div_clk_o == 1'b1, "R6 div clock high after reset", div_clk_o, 1);

      in_en = 1;
      wait_pulse();
      chk(last_meas == BASE + 48, "R8 first period", last_meas, BASE + 48);

      // endpoints
      ratio = '0;
      wait_pulse(); wait_pulse();
      chk(last_meas == BASE, "R2 shortest period", last_meas, BASE);
      ratio = '1;
      wait_pulse(); wait_pulse();
      chk(last_meas == 2 * BASE - 1, "R2 longest period", last_meas, 2 * BASE - 1);

      // sweeps: coarse over the range, fine over the 560..640 band
      prev = (1 << N) - 1;
      for (int w = 0; w < BASE; w += 8) begin
         ratio = N'(w);
         wait_pulse();
         chk(last_meas == BASE + prev, "R1 coarse sweep", last_meas, BASE + prev);
         prev = w;
      end
      for (int w = 48; w <= 128; w++) begin
         ratio = N'(w);
         wait_pulse();
         chk(last_meas == BASE + prev, "R1 band sweep", last_meas, BASE + prev);
         prev = w;
      end

      // word change inside a period
      ratio = N'(5);
      wait_pulse();
      chk(last_meas == BASE + prev, "R1 band sweep tail", last_meas, BASE + prev);
      repeat (100) @(negedge clk);
      ratio = N'(300);
      wait_pulse();
      chk(last_meas == BASE + 5, "R5 running period keeps old word", last_meas, BASE + 5);
      wait_pulse();
      chk(last_meas == BASE + 300, "R5 next period takes new word", last_meas, BASE + 300);

      // gapped enables
      ratio = N'(100);
      wait_pulse();
      lfsr = 16'hACE1;
      for (int k = 0; k < 2; k++) begin
         int target;
         target = pulses + 1;
         while (pulses < target) begin
            @(negedge clk);
            #1;
            in_en = lfsr[0] | lfsr[5];
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         end
         chk(last_meas == BASE + 100, "R7 gapped enables period", last_meas, BASE + 100);
      end
      in_en = 0;
      repeat (5) @(negedge clk);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule